// File: doc/BRIEF.md
# Serial Memory Hold and Select Controller

This block sits at the front of a serial memory slave port. It samples the chip-select, serial-clock and active-low hold pins in the system clock domain and decides whether the command and data shifter may advance. It also decides whether the serial data output may be driven, and whether the part is in active or standby power mode. A pause requested on the hold pin takes effect only at a point where the serial clock is low. If the hold edge arrives while the clock is high, the change waits until the clock next falls. While paused, the shifter is frozen, so a transfer picks up again at the same bit position.

If the part is deselected while paused, the block emits a one-cycle reset pulse to the protocol logic. After that the port stays locked until it is selected again with the hold pin already high. An internal write or erase engine reports its busy flag to this block. That flag keeps the part in active mode after deselection, and a pause never affects it.

The hold state machine has six states. IDLE means deselected. LOCKED means selected while hold was low, so the port is ignored. ACTIVE means normal shifting. ENTER_PEND means a hold fall is waiting for the clock to go low. HOLD means paused. EXIT_PEND means a hold rise is waiting for the clock to go low.

Its transitions are as follows:
- IDLE goes to ACTIVE when selected with hold high, and to LOCKED when selected with hold low.
- LOCKED goes to IDLE on deselect.
- ACTIVE goes to HOLD when hold is low and the clock is low. It goes to ENTER_PEND when hold is low and the clock is high, and to IDLE on deselect.
- ENTER_PEND goes to HOLD when the clock goes low, back to ACTIVE if hold rises first, and to IDLE on deselect.
- HOLD goes to ACTIVE when hold is high and the clock is low, and to EXIT_PEND when hold is high and the clock is high. It goes to IDLE on deselect, with a reset pulse.
- EXIT_PEND goes to ACTIVE when the clock goes low, back to HOLD if hold falls again, and to IDLE on deselect, with a reset pulse.

The power machine has two states, PWR_ACTIVE and PWR_STANDBY. It enters PWR_STANDBY when deselected and not busy, and returns to PWR_ACTIVE otherwise.

Top module: `sermem_hold_ctl`

## Requirements
- R1: Out of reset, shift_en, dq_out_oe, hold_active and iface_reset are 0 and standby is 1.
- R2: Selecting the part (cs_n low) with hold_n high sets shift_en to 1 within four system clocks. While not paused, dq_out_oe equals sdo_drive.
- R3: A hold_n fall while selected and with sck low sets hold_active to 1 and shift_en to 0 within four system clocks.
- R4: A hold_n fall while sck is high leaves hold_active at 0 and shift_en at 1 until sck goes low. After sck goes low, hold_active becomes 1.
- R5: A hold_n rise while paused with sck low clears hold_active and restores shift_en. With sck high, the exit waits until sck goes low.
- R6: While hold_active is 1, dq_out_oe and shift_en are 0 whatever sdo_drive and sck do. A busy engine does not prevent entering the pause.
- R7: Deselecting while hold_active is 1 produces exactly one iface_reset pulse of one system clock and clears hold_active.
- R8: Selecting with hold_n still low leaves hold_active and shift_en at 0. This holds even if hold_n later rises while still selected, until the part is deselected and reselected with hold_n high.
- R9: A hold_n fall while deselected sets no hold_active and no iface_reset.
- R10: standby is 0 while selected. After deselection it stays 0 while busy is 1, and becomes 1 within four system clocks once busy is 0.
- R11: Deselecting from normal (unpaused) operation produces no iface_reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, low selects |
| sck | input | 1 | Serial clock pin level |
| hold_n | input | 1 | Hold pin, low requests a pause |
| busy | input | 1 | Internal program/erase/status-write engine busy |
| sdo_drive | input | 1 | Protocol logic wants to drive the data output |
| shift_en | output | 1 | Enable for the shift clock into the shifter |
| dq_out_oe | output | 1 | Output enable for the serial data output |
| iface_reset | output | 1 | One-cycle reset pulse to the protocol logic |
| hold_active | output | 1 | Pause in effect |
| standby | output | 1 | Standby power mode flag |

## Verification
The assertions assume that the pin inputs are slow relative to the system clock. Each level must last long enough to pass the two-stage synchronizer, so that every hold and select change is seen as a clean level step. They also assume that busy and sdo_drive come from the same clock domain and need no synchronization. The bench changes the pins only on falling system-clock edges and waits several system clocks after every pin step. The random part draws the serial clock level at each hold edge and the sdo_drive values from a fixed seed, and covers both the immediate and the deferred entry and exit paths.

// File: rtl/shc_pkg.sv
package shc_pkg;
    typedef enum logic [2:0] {
        HS_IDLE,
        HS_LOCKED,
        HS_ACTIVE,
        HS_ENTER_PEND,
        HS_HOLD,
        HS_EXIT_PEND
    } hold_state_t;

    typedef enum logic {
        PWR_ACTIVE,
        PWR_STANDBY
    } pwr_state_t;
endpackage

// File: rtl/shc_sync.sv
module shc_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/shc_hold_fsm.sv
module shc_hold_fsm
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck_lvl,
    input  logic hold_lvl,
    input  logic sdo_drive,
    output logic shift_en,
    output logic dq_out_oe,
    output logic hold_active,
    output logic iface_reset
);
    hold_state_t state, nxt;
    logic        drop_in_hold;

    always_comb begin
        nxt = state;
        unique case (state)
            HS_IDLE: begin
                if (sel) nxt = hold_lvl ? HS_ACTIVE : HS_LOCKED;
            end
            HS_LOCKED: begin
                if (!sel) nxt = HS_IDLE;
            end
            HS_ACTIVE: begin
                if (!sel)           nxt = HS_IDLE;
                else if (!hold_lvl) nxt = sck_lvl ? HS_ENTER_PEND : HS_HOLD;
            end
            HS_ENTER_PEND: begin
                if (!sel)          nxt = HS_IDLE;
                else if (hold_lvl) nxt = HS_ACTIVE;
                else if (!sck_lvl) nxt = HS_HOLD;
            end
            HS_HOLD: begin
                if (!sel)          nxt = HS_IDLE;
                else if (hold_lvl) nxt = sck_lvl ? HS_EXIT_PEND : HS_ACTIVE;
            end
            HS_EXIT_PEND: begin
                if (!sel)           nxt = HS_IDLE;
                else if (!hold_lvl) nxt = HS_HOLD;
                else if (!sck_lvl)  nxt = HS_ACTIVE;
            end
            default: nxt = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= nxt;
    end

    assign drop_in_hold = !sel && (state == HS_HOLD || state == HS_EXIT_PEND);

    always_comb begin
        shift_en    = 1'b0;
        hold_active = 1'b0;
        unique case (state)
            HS_ACTIVE, HS_ENTER_PEND: shift_en    = 1'b1;
            HS_HOLD, HS_EXIT_PEND:    hold_active = 1'b1;
            HS_IDLE, HS_LOCKED:       shift_en    = 1'b0;
            default:                  shift_en    = 1'b0;
        endcase
        dq_out_oe = shift_en && sdo_drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iface_reset <= 1'b0;
        else        iface_reset <= drop_in_hold;
    end
endmodule

// File: rtl/shc_power.sv
module shc_power
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic busy,
    output logic standby
);
    pwr_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PWR_ACTIVE:  if (!sel && !busy) nxt = PWR_STANDBY;
            PWR_STANDBY: if (sel || busy)   nxt = PWR_ACTIVE;
            default:     nxt = PWR_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PWR_STANDBY;
        else        state <= nxt;
    end

    always_comb begin
        standby = (state == PWR_STANDBY);
    end
endmodule

// File: rtl/sermem_hold_ctl.sv
module sermem_hold_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic busy,
    input  logic sdo_drive,
    output logic shift_en,
    output logic dq_out_oe,
    output logic iface_reset,
    output logic hold_active,
    output logic standby
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b110;

    logic [NPIN-1:0] pins_q;
    logic sel_s, sck_s, hold_s;

    shc_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, hold_n, sck}),
        .q     (pins_q)
    );

    assign sel_s  = !pins_q[2];
    assign hold_s = pins_q[1];
    assign sck_s  = pins_q[0];

    shc_hold_fsm u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel_s),
        .sck_lvl     (sck_s),
        .hold_lvl    (hold_s),
        .sdo_drive   (sdo_drive),
        .shift_en    (shift_en),
        .dq_out_oe   (dq_out_oe),
        .hold_active (hold_active),
        .iface_reset (iface_reset)
    );

    shc_power u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_s),
        .busy    (busy),
        .standby (standby)
    );
endmodule

// File: rtl/shc_checker.sv
module shc_checker (
    input logic clk,
    input logic rst_n,
    input logic sel_s,
    input logic sck_s,
    input logic busy,
    input logic sdo_drive,
    input logic shift_en,
    input logic dq_out_oe,
    input logic iface_reset,
    input logic hold_active,
    input logic standby
);
    assert_oe_needs_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_out_oe |-> sdo_drive);

    assert_enter_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> (!$past(sck_s) && $past(sel_s)));

    assert_exit_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_active) && !iface_reset) |-> !$past(sck_s));

    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!dq_out_oe && !shift_en));

    assert_reset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iface_reset |=> !iface_reset);

    assert_reset_from_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iface_reset |-> ($past(hold_active) && !hold_active && !$past(sel_s)));

    assert_standby_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> (!$past(sel_s) && !$past(busy)));
endmodule

bind sermem_hold_ctl shc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (sel_s),
    .sck_s       (sck_s),
    .busy        (busy),
    .sdo_drive   (sdo_drive),
    .shift_en    (shift_en),
    .dq_out_oe   (dq_out_oe),
    .iface_reset (iface_reset),
    .hold_active (hold_active),
    .standby     (standby)
);

// File: tb/tb_sermem_hold_ctl.sv
`timescale 1ns/1ps
module tb_sermem_hold_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, busy = 1'b0, sdo_drive = 1'b0;
    logic shift_en, dq_out_oe, iface_reset, hold_active, standby;

    int checks = 0;
    int errors = 0;
    int rst_pulses = 0;
    int rst_run = 0;
    int rst_run_max = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sermem_hold_ctl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .busy(busy), .sdo_drive(sdo_drive), .shift_en(shift_en),
        .dq_out_oe(dq_out_oe), .iface_reset(iface_reset),
        .hold_active(hold_active), .standby(standby)
    );

    always @(negedge clk) begin
        if (rst_n && iface_reset) begin
            rst_run++;
            if (rst_run == 1) rst_pulses++;
            if (rst_run > rst_run_max) rst_run_max = rst_run;
        end else begin
            rst_run = 0;
        end
    end

    function automatic logic exp_oe(input logic paused, input logic drive);
        return !paused && drive;
    endfunction

    function automatic logic exp_immediate(input logic sck_at_edge);
        return !sck_at_edge;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        logic s;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 shift_en", shift_en, 1'b0);
        chk("R1 dq_out_oe", dq_out_oe, 1'b0);
        chk("R1 hold_active", hold_active, 1'b0);
        chk("R1 iface_reset", iface_reset, 1'b0);
        chk("R1 standby", standby, 1'b1);

        // R2 select with hold high
        cs_n = 1'b0; settle();
        chk("R2 shift_en", shift_en, 1'b1);
        chk("R10 standby selected", standby, 1'b0);
        for (int i = 0; i < 40; i++) begin
            sdo_drive = 1'($urandom);
            sck = 1'($urandom);
            @(negedge clk);
            chk("R2 oe follows drive", dq_out_oe, exp_oe(1'b0, sdo_drive));
            chk("R2 shift_en kept", shift_en, 1'b1);
        end

        // R3/R4/R5/R6 random sck level at each hold edge
        for (int i = 0; i < 20; i++) begin
            s = 1'($urandom);
            sck = s; settle();
            hold_n = 1'b0; settle();
            chk("R3 R4 entry timing", hold_active, !exp_immediate(s) ? 1'b0 : 1'b1);
            if (s) begin
                chk("R4 still shifting", shift_en, 1'b1);
                sck = 1'b0; settle();
                chk("R4 deferred entry", hold_active, 1'b1);
            end
            chk("R3 shift frozen", shift_en, 1'b0);
            for (int k = 0; k < 6; k++) begin
                sdo_drive = 1'($urandom);
                sck = 1'($urandom);
                @(negedge clk);
                chk("R6 oe off in hold", dq_out_oe, exp_oe(1'b1, sdo_drive));
                chk("R6 sck ignored", shift_en, 1'b0);
            end
            s = 1'($urandom);
            sck = s; settle();
            hold_n = 1'b1; settle();
            chk("R5 exit timing", hold_active, s);
            if (s) begin
                sck = 1'b0; settle();
                chk("R5 deferred exit", hold_active, 1'b0);
            end
            chk("R5 shift restored", shift_en, 1'b1);
        end

        // R6 busy does not block the pause
        busy = 1'b1; sck = 1'b0; settle();
        hold_n = 1'b0; settle();
        chk("R6 hold with busy", hold_active, 1'b1);
        busy = 1'b0;

        // R7 deselect during hold
        base = rst_pulses;
        cs_n = 1'b1; settle();
        chk_int("R7 one reset pulse", rst_pulses - base, 1);
        chk_int("R7 pulse width", rst_run_max, 1);
        chk("R7 hold cleared", hold_active, 1'b0);

        // R8 reselect with hold still low
        cs_n = 1'b0; settle();
        chk("R8 no hold", hold_active, 1'b0);
        chk("R8 no shift", shift_en, 1'b0);
        hold_n = 1'b1; settle();
        chk("R8 locked after hold rise", shift_en, 1'b0);
        cs_n = 1'b1; settle();
        cs_n = 1'b0; settle();
        chk("R8 resumed", shift_en, 1'b1);

        // R11 deselect from normal operation
        base = rst_pulses;
        cs_n = 1'b1; settle();
        chk_int("R11 no reset pulse", rst_pulses - base, 0);

        // R9 hold while deselected
        base = rst_pulses;
        hold_n = 1'b0; settle();
        chk("R9 no hold", hold_active, 1'b0);
        chk_int("R9 no reset pulse", rst_pulses - base, 0);
        hold_n = 1'b1; settle();

        // R10 power mode with busy
        cs_n = 1'b0; settle();
        chk("R10 active when selected", standby, 1'b0);
        busy = 1'b1;
        cs_n = 1'b1; settle(); settle();
        chk("R10 active while busy", standby, 1'b0);
        busy = 1'b0; settle();
        chk("R10 standby after busy", standby, 1'b1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule